// File: doc/BRIEF.md
# Quad Digital Potentiometer Two-Wire Slave

This block is a two-wire serial slave that controls four digital potentiometer channels. Each channel keeps a live wiper setting and four backup registers. The backup registers stand in for nonvolatile storage and are built from flip-flops. The bus lines are sampled on the system clock through a synchronizer. The data line is driven by an open-drain enable that pulls the line low. The four wiper settings leave the block as one flat parallel bus, so the analog stage next to it can use them directly.

A transfer opens with START. The first byte is an identity byte: a fixed device-type nibble followed by an instance nibble that must equal four strap inputs. This byte has no direction bit. The second byte is a command. Its upper nibble selects the operation, and its lower nibble selects a potentiometer and a backup register. The command alone decides whether a data byte follows and in which direction. Operations that move values between wipers and backup registers complete as soon as the command byte is taken. The increment/decrement command opens an unacknowledged stream of single bits. Each bit moves the chosen wiper one step, and the stream lasts until STOP.

Top module: `dpot_top`

## Requirements
- R1: A START (SDA falling while SCL is high) puts the slave into the identity-byte phase from any state, including in the middle of a transfer. A STOP (SDA rising while SCL is high) returns the slave to idle and releases SDA.
- R2: The identity byte is acknowledged (SDA pulled low during the ninth clock) only when bits 7:4 equal 0x9 and bits 3:0 equal `inst_addr_i`. Any other identity byte gets no acknowledge, and the slave then neither acknowledges nor drives SDA until the next START.
- R3: Once the identity byte matches, the next byte is always acknowledged and decoded as follows: bits 7:4 are the operation code, bits 3:2 select the potentiometer P, and bits 1:0 select the backup register R.
- R4: Operation 0xA writes the next byte, which is acknowledged, into the wiper of P. A value above 63 is stored as 63. Wiper P is shown on `wiper_o[6P+5:6P]`.
- R5: Operation 0x9 returns the wiper of P as one byte, MSB first and zero-extended to 8 bits. If the master acknowledges, the same byte is sent again. If the master does not acknowledge, SDA is released and the slave waits for STOP or START.
- R6: Operation 0xC writes the next byte, which is acknowledged and clamped to 63, into register R of P. Operation 0xB returns that register in the same way as R5.
- R7: Operation 0xD copies register R of P into the wiper of P. Operation 0xE copies the wiper of P into register R of P.
- R8: Operation 0x1 copies register R of every potentiometer into that potentiometer's wiper. Operation 0x8 copies every wiper into register R of the same potentiometer.
- R9: Operation 0x2 starts a bit stream on potentiometer P. Each bit is sampled on an SCL rise and applied on the following SCL fall: a 1 increments the wiper and a 0 decrements it. No bit in the stream is acknowledged. The stream ends at STOP, and the bit sampled just before STOP is discarded.
- R10: A stream step never moves a wiper above 63 or below 0. A step at a limit leaves the wiper unchanged.
- R11: Operation codes other than 0x1, 0x2, 0x8, 0x9, 0xA, 0xB, 0xC, 0xD and 0xE are acknowledged but change no wiper or register. Bytes that follow them are not acknowledged.
- R12: After reset, every wiper and register is 0 and SDA is released. The slave starts to pull SDA low only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8 times the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen on the pin |
| sda_i | input | 1 | Serial data line as seen on the pin |
| inst_addr_i | input | 4 | Strap value the instance nibble must match |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| wiper_o | output | 24 | Four 6-bit wiper settings, potentiometer 0 in the low bits |

## Verification
In a stream, the SCL rise that belongs to the master's STOP sequence samples a bit just as a STOP is about to arrive. A pending step and the STOP therefore meet in the same window, and the STOP has to win. The bench closes every stream by generating STOP from a low data line. It then compares the wiper on the parallel output with a count kept in the bench that applies only the bits followed by a falling edge. A second case of the same kind is a START that arrives while a data byte is half received; it is judged by checking that the aborted write leaves no trace and that the new transfer takes effect.

// File: rtl/dpot_pkg.sv
package dpot_pkg;

  // operation codes carried in bits 7:4 of the command byte
  localparam logic [3:0] INS_RESTORE_ALL = 4'h1;
  localparam logic [3:0] INS_STEP        = 4'h2;
  localparam logic [3:0] INS_STORE_ALL   = 4'h8;
  localparam logic [3:0] INS_RD_WIPER    = 4'h9;
  localparam logic [3:0] INS_WR_WIPER    = 4'hA;
  localparam logic [3:0] INS_RD_REG      = 4'hB;
  localparam logic [3:0] INS_WR_REG      = 4'hC;
  localparam logic [3:0] INS_REG2WIPER   = 4'hD;
  localparam logic [3:0] INS_WIPER2REG   = 4'hE;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_CMD, ST_WDATA, ST_RDATA, ST_STREAM, ST_WAIT
  } eng_state_e;

  typedef enum logic [2:0] {
    OP_NONE, OP_RESTORE_ALL, OP_STORE_ALL, OP_WR_WIPER,
    OP_WR_REG, OP_R2W, OP_W2R, OP_STEP
  } op_kind_e;

  // identity byte hit: type nibble and strap nibble both equal
  function automatic logic f_addr_hit(input logic [7:0] b,
                                      input logic [3:0] dev_type,
                                      input logic [3:0] inst);
    return (b[7:4] == dev_type) && (b[3:0] == inst);
  endfunction

  // limit an incoming byte to the wiper range
  function automatic logic [7:0] f_clamp(input logic [7:0] v,
                                         input logic [7:0] mx);
    return (v > mx) ? mx : v;
  endfunction

  // one saturating step up or down
  function automatic logic [7:0] f_step(input logic [7:0] v,
                                        input logic up,
                                        input logic [7:0] mx);
    if (up) return (v >= mx) ? mx : v + 8'd1;
    else    return (v == 8'd0) ? 8'd0 : v - 8'd1;
  endfunction

endpackage

// File: rtl/dpot_line_sync.sv
module dpot_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic [STAGES-1:0] scl_q, sda_q;
  logic scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= '1;
      sda_q <= '1;
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_q <= {scl_q[STAGES-2:0], scl_i};
      sda_q <= {sda_q[STAGES-2:0], sda_i};
      scl_d <= scl_q[STAGES-1];
      sda_d <= sda_q[STAGES-1];
    end
  end

  assign scl_s     = scl_q[STAGES-1];
  assign sda_s     = sda_q[STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_evt = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_evt  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/dpot_bus_engine.sv
module dpot_bus_engine
  import dpot_pkg::*;
#(
  parameter logic [3:0] DEV_TYPE = 4'h9
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sda_s,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_evt,
  input  logic       stop_evt,
  input  logic [3:0] inst_addr,
  input  logic [7:0] rd_wiper,
  input  logic [7:0] rd_reg,
  output logic [1:0] rd_pot_sel,
  output logic [1:0] rd_reg_sel,
  output logic       sda_oe,
  output eng_state_e state,
  output op_kind_e   op_kind,
  output logic [1:0] op_pot,
  output logic [1:0] op_reg,
  output logic [7:0] op_data,
  output logic       op_up
);
  eng_state_e after_ack;
  logic [3:0] cnt;
  logic [7:0] shreg, cmd_q, txbyte, txsh;
  logic       ack_ph, mack, sbit, pend;
  logic [3:0] ins;

  assign ins        = shreg[7:4];
  assign rd_pot_sel = shreg[3:2];
  assign rd_reg_sel = shreg[1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      after_ack <= ST_WAIT;
      cnt       <= '0;
      shreg     <= '0;
      cmd_q     <= '0;
      txbyte    <= '0;
      txsh      <= '0;
      ack_ph    <= 1'b0;
      mack      <= 1'b1;
      sbit      <= 1'b0;
      pend      <= 1'b0;
      sda_oe    <= 1'b0;
      op_kind   <= OP_NONE;
      op_pot    <= '0;
      op_reg    <= '0;
      op_data   <= '0;
      op_up     <= 1'b0;
    end else begin
      op_kind <= OP_NONE;
      if (start_evt) begin
        state  <= ST_ADDR;
        cnt    <= '0;
        ack_ph <= 1'b0;
        pend   <= 1'b0;
        sda_oe <= 1'b0;
      end else if (stop_evt) begin
        state  <= ST_IDLE;
        cnt    <= '0;
        ack_ph <= 1'b0;
        pend   <= 1'b0;
        sda_oe <= 1'b0;
      end else begin
        case (state)
          ST_ADDR, ST_CMD, ST_WDATA: begin
            if (scl_rise && !ack_ph && cnt < 4'd8) begin
              shreg <= {shreg[6:0], sda_s};
              cnt   <= cnt + 4'd1;
            end
            if (scl_fall) begin
              if (ack_ph) begin
                // end of the acknowledge clock
                ack_ph <= 1'b0;
                cnt    <= '0;
                state  <= after_ack;
                sda_oe <= (after_ack == ST_RDATA) ? ~txbyte[7] : 1'b0;
                txsh   <= {txbyte[6:0], 1'b0};
              end else if (cnt == 4'd8) begin
                // a full byte is in
                if (state == ST_ADDR) begin
                  if (f_addr_hit(shreg, DEV_TYPE, inst_addr)) begin
                    sda_oe    <= 1'b1;
                    ack_ph    <= 1'b1;
                    after_ack <= ST_CMD;
                  end else begin
                    state <= ST_WAIT;
                  end
                end else if (state == ST_CMD) begin
                  sda_oe    <= 1'b1;
                  ack_ph    <= 1'b1;
                  cmd_q     <= shreg;
                  op_pot    <= shreg[3:2];
                  op_reg    <= shreg[1:0];
                  after_ack <= ST_WAIT;
                  case (ins)
                    INS_RD_WIPER: begin
                      txbyte    <= rd_wiper;
                      after_ack <= ST_RDATA;
                    end
                    INS_RD_REG: begin
                      txbyte    <= rd_reg;
                      after_ack <= ST_RDATA;
                    end
                    INS_WR_WIPER, INS_WR_REG: after_ack <= ST_WDATA;
                    INS_STEP:        after_ack <= ST_STREAM;
                    INS_RESTORE_ALL: op_kind <= OP_RESTORE_ALL;
                    INS_STORE_ALL:   op_kind <= OP_STORE_ALL;
                    INS_REG2WIPER:   op_kind <= OP_R2W;
                    INS_WIPER2REG:   op_kind <= OP_W2R;
                    default:         after_ack <= ST_WAIT;
                  endcase
                end else begin
                  sda_oe    <= 1'b1;
                  ack_ph    <= 1'b1;
                  after_ack <= ST_WAIT;
                  op_data   <= shreg;
                  op_pot    <= cmd_q[3:2];
                  op_reg    <= cmd_q[1:0];
                  op_kind   <= (cmd_q[7:4] == INS_WR_REG) ? OP_WR_REG : OP_WR_WIPER;
                end
              end
            end
          end
          ST_RDATA: begin
            if (scl_rise) begin
              if (cnt == 4'd8) mack <= sda_s;
              if (cnt < 4'd9) cnt <= cnt + 4'd1;
            end
            if (scl_fall) begin
              if (cnt >= 4'd1 && cnt < 4'd8) begin
                sda_oe <= ~txsh[7];
                txsh   <= {txsh[6:0], 1'b0};
              end else if (cnt == 4'd8) begin
                sda_oe <= 1'b0;
              end else if (cnt == 4'd9) begin
                if (!mack) begin
                  cnt    <= '0;
                  sda_oe <= ~txbyte[7];
                  txsh   <= {txbyte[6:0], 1'b0};
                end else begin
                  sda_oe <= 1'b0;
                  state  <= ST_WAIT;
                end
              end
            end
          end
          ST_STREAM: begin
            if (scl_rise) begin
              pend <= 1'b1;
              sbit <= sda_s;
            end
            if (scl_fall && pend) begin
              pend    <= 1'b0;
              op_kind <= OP_STEP;
              op_up   <= sbit;
              op_pot  <= cmd_q[3:2];
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/dpot_store.sv
module dpot_store
  import dpot_pkg::*;
#(
  parameter int NPOT    = 4,
  parameter int NREG    = 4,
  parameter int WIPER_W = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  op_kind_e   op_kind,
  input  logic [1:0] op_pot,
  input  logic [1:0] op_reg,
  input  logic [7:0] op_data,
  input  logic       op_up,
  input  logic [1:0] rd_pot_sel,
  input  logic [1:0] rd_reg_sel,
  output logic [7:0] rd_wiper,
  output logic [7:0] rd_reg,
  output logic [NPOT-1:0][WIPER_W-1:0] wiper_all
);
  localparam int         WIPER_MAX = (1 << WIPER_W) - 1;
  localparam logic [7:0] MAX8      = 8'(WIPER_MAX);

  logic [NPOT-1:0][NREG-1:0][WIPER_W-1:0] nv_all;

  for (genvar p = 0; p < NPOT; p++) begin : g_pot
    localparam logic [1:0] ME = 2'(p);
    logic [WIPER_W-1:0]            wiper_r;
    logic [NREG-1:0][WIPER_W-1:0]  nv_r;
    logic                          hit;

    assign hit = (op_pot == ME);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        wiper_r <= '0;
        nv_r    <= '0;
      end else begin
        case (op_kind)
          OP_RESTORE_ALL: wiper_r <= nv_r[op_reg];
          OP_STORE_ALL:   nv_r[op_reg] <= wiper_r;
          OP_WR_WIPER: if (hit) wiper_r <= WIPER_W'(f_clamp(op_data, MAX8));
          OP_WR_REG:   if (hit) nv_r[op_reg] <= WIPER_W'(f_clamp(op_data, MAX8));
          OP_R2W:      if (hit) wiper_r <= nv_r[op_reg];
          OP_W2R:      if (hit) nv_r[op_reg] <= wiper_r;
          OP_STEP:     if (hit) wiper_r <= WIPER_W'(f_step(8'(wiper_r), op_up, MAX8));
          default: ;
        endcase
      end
    end

    assign wiper_all[p] = wiper_r;
    assign nv_all[p]    = nv_r;
  end

  assign rd_wiper = 8'(wiper_all[rd_pot_sel]);
  assign rd_reg   = 8'(nv_all[rd_pot_sel][rd_reg_sel]);
endmodule

// File: rtl/dpot_top.sv
module dpot_top
  import dpot_pkg::*;
#(
  parameter logic [3:0] DEV_TYPE    = 4'h9,
  parameter int         SYNC_STAGES = 2,
  parameter int         WIPER_W     = 6
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      scl_i,
  input  logic                      sda_i,
  input  logic [3:0]                inst_addr_i,
  output logic                      sda_oe_o,
  output logic [4*WIPER_W-1:0]      wiper_o
);
  localparam int SEL_W = 2;
  localparam int NPOT  = 1 << SEL_W;
  localparam int NREG  = 1 << SEL_W;

  logic scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;
  logic [1:0] rd_pot_sel, rd_reg_sel, op_pot, op_reg;
  logic [7:0] rd_wiper, rd_reg, op_data;
  logic       op_up;
  eng_state_e eng_state;
  op_kind_e   op_kind;
  logic [NPOT-1:0][WIPER_W-1:0] wiper_all;

  dpot_line_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  dpot_bus_engine #(.DEV_TYPE(DEV_TYPE)) eng_i (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_evt(start_evt), .stop_evt(stop_evt),
    .inst_addr(inst_addr_i), .rd_wiper(rd_wiper), .rd_reg(rd_reg),
    .rd_pot_sel(rd_pot_sel), .rd_reg_sel(rd_reg_sel), .sda_oe(sda_oe_o),
    .state(eng_state), .op_kind(op_kind), .op_pot(op_pot), .op_reg(op_reg),
    .op_data(op_data), .op_up(op_up)
  );

  dpot_store #(.NPOT(NPOT), .NREG(NREG), .WIPER_W(WIPER_W)) store_i (
    .clk(clk), .rst_n(rst_n), .op_kind(op_kind), .op_pot(op_pot),
    .op_reg(op_reg), .op_data(op_data), .op_up(op_up),
    .rd_pot_sel(rd_pot_sel), .rd_reg_sel(rd_reg_sel),
    .rd_wiper(rd_wiper), .rd_reg(rd_reg), .wiper_all(wiper_all)
  );

  assign wiper_o = wiper_all;
endmodule

// File: rtl/dpot_checker.sv
module dpot_checker
  import dpot_pkg::*;
#(
  parameter int NPOT    = 4,
  parameter int WIPER_W = 6
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    scl_s,
  input logic                    sda_oe,
  input logic                    stop_evt,
  input eng_state_e              state,
  input op_kind_e                op_kind,
  input logic [1:0]              op_pot,
  input logic                    op_up,
  input logic [NPOT*WIPER_W-1:0] wiper_flat
);
  localparam logic [WIPER_W-1:0] TOP = '1;
  logic [WIPER_W-1:0] cur;
  assign cur = wiper_flat[op_pot*WIPER_W +: WIPER_W];

  // R12: the slave begins pulling SDA low only in the SCL low phase
  p_drive_scl_low_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s);

  // R1: a STOP leaves the slave idle with SDA released
  p_stop_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> (state == ST_IDLE && !sda_oe));

  // R2: after a non-matching identity byte nothing is driven
  p_ignore_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAIT) |-> !sda_oe);

  // R9: stream bits are never acknowledged
  p_stream_no_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_STREAM) |-> !sda_oe);

  // R10: an upward step at the top leaves the wipers unchanged
  p_sat_top_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (op_kind == OP_STEP && op_up && cur == TOP) |=> $stable(wiper_flat));

  // R10: a downward step at zero leaves the wipers unchanged
  p_sat_bottom_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (op_kind == OP_STEP && !op_up && cur == '0) |=> $stable(wiper_flat));
endmodule

bind dpot_top dpot_checker #(.NPOT(NPOT), .WIPER_W(WIPER_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_oe(sda_oe_o),
  .stop_evt(stop_evt), .state(eng_state), .op_kind(op_kind),
  .op_pot(op_pot), .op_up(op_up), .wiper_flat(wiper_o)
);

// File: tb/dpot_top_tb_top.sv
`timescale 1ns/1ps
module dpot_top_tb_top;
  localparam int Q = 8;
  localparam logic [3:0] INST = 4'h5;
  localparam logic [7:0] ID   = {4'h9, INST};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe_o;
  logic [23:0] wiper_o;
  wire  sda_bus = sda_m & ~sda_oe_o;

  int n_run = 0, n_fail = 0;
  logic [5:0] exp_w [4];
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dpot_top dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .inst_addr_i(INST), .sda_oe_o(sda_oe_o), .wiper_o(wiper_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wq(); repeat (Q) @(negedge clk); endtask

  task automatic clock_bit(input logic b, output logic r);
    sda_m = b; wq();
    scl_m = 1'b1; wq();
    r = sda_bus; wq();
    scl_m = 1'b0; wq();
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq();
    sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
  endtask

  task automatic put_byte(input logic [7:0] b, output bit acked);
    logic r;
    for (int i = 7; i >= 0; i--) clock_bit(b[i], r);
    clock_bit(1'b1, r);
    acked = (r == 1'b0);
  endtask

  task automatic get_byte(input bit give_ack, output logic [7:0] b);
    logic r;
    for (int i = 7; i >= 0; i--) begin clock_bit(1'b1, r); b[i] = r; end
    clock_bit(give_ack ? 1'b0 : 1'b1, r);
  endtask

  function automatic logic [23:0] packed_exp();
    return {exp_w[3], exp_w[2], exp_w[1], exp_w[0]};
  endfunction

  function automatic logic [5:0] lim(input logic [7:0] v);
    return (v > 8'd63) ? 6'd63 : v[5:0];
  endfunction

  // start, identity byte and command byte, both must be acknowledged
  task automatic open_cmd(input logic [7:0] cmd, input string req);
    bit a;
    bus_start();
    put_byte(ID, a);  chk(a, "R2", "identity ack", a, 1);
    put_byte(cmd, a); chk(a, req, "command ack", a, 1);
  endtask

  task automatic wr_wiper(input int p, input logic [7:0] v);
    bit a;
    open_cmd({4'hA, 2'(p), 2'b00}, "R3");
    put_byte(v, a); chk(a, "R4", "data ack", a, 1);
    bus_stop();
    exp_w[p] = lim(v);
  endtask

  task automatic stream(input int p, input logic [7:0] bits, input int n);
    logic r;
    open_cmd({4'h2, 2'(p), 2'b00}, "R9");
    for (int i = 0; i < n; i++) begin
      clock_bit(bits[i], r);
      if (bits[i]) chk(r == 1'b1, "R9", "stream bit not acked", r, 1);
      if (bits[i]) exp_w[p] = (exp_w[p] == 6'd63) ? 6'd63 : exp_w[p] + 6'd1;
      else         exp_w[p] = (exp_w[p] == 6'd0) ? 6'd0 : exp_w[p] - 6'd1;
    end
    bus_stop();
  endtask

  task automatic t_reset();
    chk(sda_oe_o == 1'b0, "R12", "SDA released at reset", sda_oe_o, 0);
    chk(wiper_o == '0, "R12", "wipers zero at reset", wiper_o, 0);
  endtask

  task automatic t_wiper_rw();
    logic [7:0] b;
    wr_wiper(2, 8'h25);
    chk(wiper_o == packed_exp(), "R4", "wiper2 write", wiper_o, packed_exp());
    wr_wiper(1, 8'hC8);
    chk(wiper_o[11:6] == 6'd63, "R4", "write clamp", wiper_o[11:6], 63);
    open_cmd(8'h98, "R3");
    get_byte(1'b1, b); chk(b == 8'h25, "R5", "read wiper", b, 8'h25);
    get_byte(1'b0, b); chk(b == 8'h25, "R5", "repeat after ack", b, 8'h25);
    chk(sda_oe_o == 1'b0, "R5", "released after nack", sda_oe_o, 0);
    bus_stop();
  endtask

  task automatic t_reg_rw();
    logic [7:0] b; bit a;
    open_cmd(8'hC7, "R3"); put_byte(8'h11, a);
    chk(a, "R6", "reg write ack", a, 1); bus_stop();
    open_cmd(8'hB7, "R3"); get_byte(1'b0, b); bus_stop();
    chk(b == 8'h11, "R6", "reg read", b, 8'h11);
    open_cmd(8'hC7, "R3"); put_byte(8'hFF, a); bus_stop();
    open_cmd(8'hB7, "R3"); get_byte(1'b0, b); bus_stop();
    chk(b == 8'h3F, "R6", "reg clamp", b, 8'h3F);
  endtask

  task automatic t_transfer();
    open_cmd(8'hE9, "R3"); bus_stop();       // wiper2 -> reg1 of pot2
    wr_wiper(2, 8'h00);
    chk(wiper_o == packed_exp(), "R7", "wiper2 cleared", wiper_o, packed_exp());
    open_cmd(8'hD9, "R3"); bus_stop();       // reg1 -> wiper2
    exp_w[2] = 6'h25;
    chk(wiper_o == packed_exp(), "R7", "reg to wiper", wiper_o, packed_exp());
  endtask

  task automatic t_all();
    logic [7:0] b;
    logic [5:0] keep [4];
    wr_wiper(0, 8'd11); wr_wiper(1, 8'd22); wr_wiper(2, 8'd33); wr_wiper(3, 8'd44);
    for (int p = 0; p < 4; p++) keep[p] = exp_w[p];
    open_cmd(8'h82, "R3"); bus_stop();       // all wipers -> reg2
    for (int p = 0; p < 4; p++) wr_wiper(p, 8'd0);
    chk(wiper_o == '0, "R8", "wipers cleared", wiper_o, 0);
    open_cmd(8'hB6, "R3"); get_byte(1'b0, b); bus_stop();
    chk(b == 8'd22, "R8", "stored reg2 of pot1", b, 22);
    open_cmd(8'h12, "R3"); bus_stop();       // reg2 -> all wipers
    for (int p = 0; p < 4; p++) exp_w[p] = keep[p];
    chk(wiper_o == packed_exp(), "R8", "restore all", wiper_o, packed_exp());
  endtask

  task automatic t_stream();
    wr_wiper(0, 8'd5);
    stream(0, 8'b0111, 4);                   // up,up,up,down
    chk(wiper_o == packed_exp(), "R9", "stream result", wiper_o, packed_exp());
    chk(exp_w[0] == 6'd7, "R9", "model value", exp_w[0], 7);
  endtask

  task automatic t_sat();
    wr_wiper(3, 8'd62);
    stream(3, 8'b111, 3);
    chk(wiper_o[23:18] == 6'd63, "R10", "top saturation", wiper_o[23:18], 63);
    wr_wiper(3, 8'd1);
    stream(3, 8'b000, 3);
    chk(wiper_o[23:18] == 6'd0, "R10", "bottom saturation", wiper_o[23:18], 0);
  endtask

  task automatic t_mismatch();
    bit a;
    logic [23:0] snap;
    snap = wiper_o;
    bus_start();
    put_byte({4'h9, INST ^ 4'h3}, a); chk(!a, "R2", "wrong instance nack", a, 0);
    put_byte(8'hA0, a); chk(!a, "R2", "ignored cmd nack", a, 0);
    put_byte(8'h30, a); chk(!a, "R2", "ignored data nack", a, 0);
    bus_stop();
    bus_start();
    put_byte({4'h5, INST}, a); chk(!a, "R2", "wrong type nack", a, 0);
    bus_stop();
    chk(wiper_o == snap, "R2", "wipers untouched", wiper_o, snap);
  endtask

  task automatic t_undef();
    bit a;
    logic [7:0] b;
    logic [23:0] snap;
    snap = wiper_o;
    open_cmd(8'h34, "R11");
    put_byte(8'hFF, a); chk(!a, "R11", "byte after undefined nack", a, 0);
    bus_stop();
    open_cmd(8'h70, "R11"); bus_stop();
    chk(wiper_o == snap, "R11", "wipers unchanged", wiper_o, snap);
    open_cmd(8'hB3, "R3"); get_byte(1'b0, b); bus_stop();
    chk(b == 8'h00, "R11", "reg3 pot0 unchanged", b, 0);
  endtask

  task automatic t_restart();
    bit a; logic r;
    open_cmd(8'hA0, "R3");
    for (int i = 0; i < 3; i++) clock_bit(1'b1, r);   // partial data byte
    open_cmd(8'hA0, "R1");                             // repeated START
    put_byte(8'h0A, a); chk(a, "R1", "data ack after restart", a, 1);
    bus_stop();
    exp_w[0] = 6'd10;
    chk(wiper_o == packed_exp(), "R1", "restart write", wiper_o, packed_exp());
    chk(sda_oe_o == 1'b0, "R1", "released after stop", sda_oe_o, 0);
  endtask

  initial begin
    for (int p = 0; p < 4; p++) exp_w[p] = '0;
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_wiper_rw();
    t_reg_rw();
    t_transfer();
    t_all();
    t_stream();
    t_sat();
    t_mismatch();
    t_undef();
    t_restart();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=hung expected=complete");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule